// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Sequencer Core

This block is a compact 8-bit processor core with its own 256-byte single-port RAM. It holds an 8-bit program counter and three general registers (A, B, C). Each instruction is one opcode byte, optionally followed by inline bytes: a target address, a source address, a literal and a jump address. The sequencer spends one cycle per memory access. It fetches the opcode, then each inline byte the instruction needs, then any indirect operand reads, and then executes in a final cycle that may write memory, a register or the program counter.

A loader port writes the program into RAM while reset is held. The same address bus reads RAM back combinationally at any time, so a harness can inspect results. A halt input freezes the sequencer in place. A one-cycle done pulse marks the end of every instruction, so a harness can single-step the core. Arithmetic opcodes belong to a separate datapath and execute here as one-byte no-operations.

Top module: `tcpu`

## Requirements
- R1: While reset is held and just after it is released, the program counter is 0x20, registers A, B and C are 0x00 and done is low.
- R2: An operand field (opcode bits [5:4] for the target, [7:6] for the source) selects A with 0, B with 1 and C with 2. Code 3 selects the memory byte whose address is the next inline byte.
- R3: Inline bytes follow the opcode in a fixed order. The target address comes first, then the source address, then the literal (for the literal load), and the jump address comes last.
- R4: Low nibble 0x2 copies S to T. Low nibble 0x3 sets T to mem[S]. Low nibble 0x4 sets mem[T] to S.
- R5: Opcode 0x11 jumps to the inline address. Opcodes 0b01TT0001 load the inline literal into T.
- R6: Low nibbles 0x5, 0x6 and 0x7 jump when T==S, when T!=S, or when T<S as signed bytes. When the jump is not taken, execution continues after the address byte.
- R7: Opcodes 0b10TT0001 store the address of the byte after the whole instruction into T and then jump. Opcodes 0b11TT0001 load the program counter from T.
- R8: Opcode 0x21 copies mem[A] to mem[B] and then increments both A and B.
- R9: All other opcodes are one-byte no-operations. This covers low nibble 0x0, low nibbles 0x8 to 0xF, and 0x01 and 0x31.
- R10: While halt is high, the program counter, the registers and the RAM do not change and done stays low.
- R11: Done is high for exactly one cycle after each completed instruction.
- R12: The loader writes RAM only while reset is held and is ignored otherwise. Its read data always shows RAM at the loader address.
- R13: The program counter wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables loading |
| halt | input | 1 | Freezes the sequencer while high |
| ext_we | input | 1 | Loader write strobe (honoured only in reset) |
| ext_addr | input | 8 | Loader write/read address |
| ext_wdata | input | 8 | Loader write data |
| ext_rdata | output | 8 | RAM contents at ext_addr |
| done | output | 1 | One-cycle pulse per completed instruction |
| pc | output | 8 | Program counter |
| reg_a | output | 8 | Register A |
| reg_b | output | 8 | Register B |
| reg_c | output | 8 | Register C |

## Verification
The bench targets inline-byte ordering with an instruction where both operands are memory addresses: a core that swapped the two bytes would copy in the wrong direction and leave the checked cell at zero. Conditional jumps are run both taken and not taken. A core that forgot the unused address byte would land one address early, and an unsigned comparison would invert the result for 0xFF against 0x01. The call checks pin the saved return address to the byte after the instruction and catch an off-by-one in the stored value. A jump to 0xFF checks the counter wrap to 0x00. Halt and a loader write issued while running are both checked to leave state untouched.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

   typedef enum logic [3:0] {
      ST_FETCH, ST_TADR, ST_SADR, ST_LIT, ST_JADR,
      ST_TRD, ST_SRD, ST_IND, ST_EXEC
   } st_e;

   typedef enum logic [3:0] {
      K_NOP, K_JMP, K_SCP, K_MVL, K_CAL, K_RET,
      K_MOV, K_MFR, K_MTR, K_JEQ, K_JNE, K_JLT
   } kind_e;

   // per-instruction plan: which cycles the sequencer must spend
   typedef struct packed {
      kind_e kind;
      logic  t_adr;   // inline target address byte
      logic  s_adr;   // inline source address byte
      logic  lit;     // inline literal byte
      logic  jadr;    // inline jump address byte
      logic  t_mrd;   // read memory target value
      logic  s_mrd;   // read memory source value
      logic  ind;     // second-level indirect read
      logic  wr_t;    // result goes to target
   } dec_s;

   localparam logic [1:0] CODE_MEM = 2'd3;

endpackage

// File: rtl/tcpu_ram.sv
module tcpu_ram #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          load_mode,
   input  logic          we,
   input  logic [DW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          ext_we,
   input  logic [DW-1:0] ext_addr,
   input  logic [DW-1:0] ext_wdata,
   output logic [DW-1:0] ext_rdata
);
   localparam int DEPTH = 1 << DW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (load_mode) begin
         if (ext_we) mem[ext_addr] <= ext_wdata;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata     = mem[addr];
   assign ext_rdata = mem[ext_addr];

   // R12: the core never competes with the loader
   a_r12_core_quiet_in_load: assert property (@(posedge clk) load_mode |-> !we)
      else $error("core wrote RAM during load");

endmodule

// File: rtl/tcpu_decode.sv
module tcpu_decode
   import tcpu_pkg::*;
(
   input  logic [7:0] op,
   output dec_s       dec
);
   logic       t_used, s_used, t_val, s_val;
   logic [1:0] tcode, scode;

   assign tcode = op[5:4];
   assign scode = op[7:6];

   always_comb begin
      dec    = '0;
      t_used = 1'b0;
      s_used = 1'b0;
      t_val  = 1'b0;
      s_val  = 1'b0;
      dec.kind = K_NOP;
      unique case (op[3:0])
         4'h1: begin
            unique case (scode)
               2'b00: begin
                  if (tcode == 2'b01) begin
                     dec.kind = K_JMP; dec.jadr = 1'b1;
                  end else if (tcode == 2'b10) begin
                     dec.kind = K_SCP; dec.s_mrd = 1'b1;
                  end
               end
               2'b01: begin dec.kind = K_MVL; t_used = 1'b1; dec.lit = 1'b1; dec.wr_t = 1'b1; end
               2'b10: begin dec.kind = K_CAL; t_used = 1'b1; dec.jadr = 1'b1; dec.wr_t = 1'b1; end
               default: begin dec.kind = K_RET; t_used = 1'b1; t_val = 1'b1; end
            endcase
         end
         4'h2: begin dec.kind = K_MOV; t_used = 1'b1; s_used = 1'b1; s_val = 1'b1; dec.wr_t = 1'b1; end
         4'h3: begin dec.kind = K_MFR; t_used = 1'b1; s_used = 1'b1; s_val = 1'b1; dec.ind = 1'b1; dec.wr_t = 1'b1; end
         4'h4: begin dec.kind = K_MTR; t_used = 1'b1; s_used = 1'b1; t_val = 1'b1; s_val = 1'b1; end
         4'h5, 4'h6, 4'h7: begin
            dec.kind = (op[3:0] == 4'h5) ? K_JEQ : (op[3:0] == 4'h6) ? K_JNE : K_JLT;
            t_used = 1'b1; s_used = 1'b1; t_val = 1'b1; s_val = 1'b1; dec.jadr = 1'b1;
         end
         default: dec.kind = K_NOP;
      endcase
      dec.t_adr = t_used && (tcode == CODE_MEM);
      dec.s_adr = s_used && (scode == CODE_MEM);
      dec.t_mrd = t_val  && (tcode == CODE_MEM);
      dec.s_mrd = dec.s_mrd || (s_val && (scode == CODE_MEM));
   end

endmodule

// File: rtl/tcpu_seq.sv
module tcpu_seq
   import tcpu_pkg::*;
#(
   parameter int          DW       = 8,
   parameter logic [DW-1:0] RESET_PC = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          halt,
   output logic [DW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] pc,
   output logic [DW-1:0] reg_a,
   output logic [DW-1:0] reg_b,
   output logic [DW-1:0] reg_c,
   output logic          done
);
   localparam int NREG = 3;

   st_e           st_q;
   logic [DW-1:0] pc_q, ir_q, tadr_q, sadr_q, lit_q, jadr_q, tmem_q, smem_q, ind_q;
   logic          done_q;
   dec_s          dec;
   logic [7:0]    ir_sel;
   logic          adv, byte_st, take;
   logic [DW-1:0] rf [NREG];
   logic [NREG-1:0] rf_we;
   logic [DW-1:0] rf_wd [NREG];
   logic [DW-1:0] tval, sval, wval;
   logic [1:0]    tcode, scode;

   assign adv    = !halt;
   assign ir_sel = (st_q == ST_FETCH) ? mem_rdata : ir_q;
   assign tcode  = ir_q[5:4];
   assign scode  = ir_q[7:6];

   tcpu_decode u_dec (.op(ir_sel), .dec(dec));

   // register file, one storage element per general register
   for (genvar g = 0; g < NREG; g++) begin : g_rf
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= '0;
         else if (rf_we[g]) q <= rf_wd[g];
      end
      assign rf[g] = q;
   end

   function automatic logic [DW-1:0] pick(input logic [1:0] c, input logic [DW-1:0] m);
      unique case (c)
         2'd0:    return rf[0];
         2'd1:    return rf[1];
         2'd2:    return rf[2];
         default: return m;
      endcase
   endfunction

   assign tval = pick(tcode, tmem_q);
   assign sval = pick(scode, smem_q);

   // next state: earliest remaining step after the current one
   function automatic st_e after(input st_e cur, input dec_s d);
      st_e n = ST_EXEC;
      if (cur < ST_IND  && d.ind)   n = ST_IND;
      if (cur < ST_SRD  && d.s_mrd) n = ST_SRD;
      if (cur < ST_TRD  && d.t_mrd) n = ST_TRD;
      if (cur < ST_JADR && d.jadr)  n = ST_JADR;
      if (cur < ST_LIT  && d.lit)   n = ST_LIT;
      if (cur < ST_SADR && d.s_adr) n = ST_SADR;
      if (cur < ST_TADR && d.t_adr) n = ST_TADR;
      return n;
   endfunction

   assign byte_st = (st_q == ST_FETCH) || (st_q == ST_TADR) || (st_q == ST_SADR) ||
                    (st_q == ST_LIT)   || (st_q == ST_JADR);

   always_comb begin
      unique case (dec.kind)
         K_MVL:   wval = lit_q;
         K_CAL:   wval = pc_q;
         K_MFR:   wval = ind_q;
         default: wval = sval;
      endcase
      unique case (dec.kind)
         K_JMP, K_CAL: take = 1'b1;
         K_JEQ:        take = (tval == sval);
         K_JNE:        take = (tval != sval);
         K_JLT:        take = ($signed(tval) < $signed(sval));
         default:      take = 1'b0;
      endcase
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = wval;
      rf_we     = '0;
      for (int i = 0; i < NREG; i++) rf_wd[i] = wval;
      unique case (st_q)
         ST_TRD:  mem_addr = tadr_q;
         ST_SRD:  mem_addr = (dec.kind == K_SCP) ? rf[0] : sadr_q;
         ST_IND:  mem_addr = sval;
         ST_EXEC: mem_addr = tadr_q;
         default: mem_addr = pc_q;
      endcase
      if (st_q == ST_EXEC && adv) begin
         if (dec.wr_t) begin
            if (tcode == CODE_MEM) mem_we = 1'b1;
            else                   rf_we[tcode] = 1'b1;
         end
         if (dec.kind == K_MTR) begin
            mem_we = 1'b1; mem_addr = tval; mem_wdata = sval;
         end
         if (dec.kind == K_SCP) begin
            mem_we = 1'b1; mem_addr = rf[1]; mem_wdata = smem_q;
            rf_we[0] = 1'b1; rf_wd[0] = rf[0] + 1'b1;
            rf_we[1] = 1'b1; rf_wd[1] = rf[1] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_FETCH;
         pc_q   <= RESET_PC;
         ir_q   <= '0;
         tadr_q <= '0; sadr_q <= '0; lit_q <= '0; jadr_q <= '0;
         tmem_q <= '0; smem_q <= '0; ind_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= adv && (st_q == ST_EXEC);
         if (adv) begin
            if (byte_st) pc_q <= pc_q + 1'b1;
            unique case (st_q)
               ST_FETCH: ir_q   <= mem_rdata;
               ST_TADR:  tadr_q <= mem_rdata;
               ST_SADR:  sadr_q <= mem_rdata;
               ST_LIT:   lit_q  <= mem_rdata;
               ST_JADR:  jadr_q <= mem_rdata;
               ST_TRD:   tmem_q <= mem_rdata;
               ST_SRD:   smem_q <= mem_rdata;
               ST_IND:   ind_q  <= mem_rdata;
               default: begin
                  if (dec.kind == K_RET) pc_q <= tval;
                  else if (take)         pc_q <= jadr_q;
               end
            endcase
            st_q <= (st_q == ST_EXEC) ? ST_FETCH : after(st_q, dec);
         end
      end
   end

   assign pc    = pc_q;
   assign reg_a = rf[0];
   assign reg_b = rf[1];
   assign reg_c = rf[2];
   assign done  = done_q;

   // R10: halt freezes the counter and blocks writes
   a_r10_halt_pc: assert property (@(posedge clk) disable iff (!rst_n) halt |=> $stable(pc_q))
      else $error("pc moved under halt");
   a_r10_halt_nowrite: assert property (@(posedge clk) disable iff (!rst_n) halt |-> !mem_we)
      else $error("RAM write under halt");
   // R11: done is a single-cycle pulse
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q)
      else $error("done held high");
   // R3 / R13: every inline byte advances the counter by one, modulo 256
   a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_st && adv) |=> pc_q == $past(pc_q) + 1'b1)
      else $error("byte fetch did not step pc");

endmodule

// File: rtl/tcpu.sv
module tcpu #(
   parameter int            DW       = 8,
   parameter logic [DW-1:0] RESET_PC = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          halt,
   input  logic          ext_we,
   input  logic [DW-1:0] ext_addr,
   input  logic [DW-1:0] ext_wdata,
   output logic [DW-1:0] ext_rdata,
   output logic          done,
   output logic [DW-1:0] pc,
   output logic [DW-1:0] reg_a,
   output logic [DW-1:0] reg_b,
   output logic [DW-1:0] reg_c
);
   if (DW != 8) begin : g_bad_dw
      $error("tcpu: opcode fields assume an 8-bit word");
   end

   logic          m_we;
   logic [DW-1:0] m_addr, m_wdata, m_rdata;

   tcpu_ram #(.DW(DW)) u_ram (
      .clk(clk), .load_mode(!rst_n),
      .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata),
      .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
   );

   tcpu_seq #(.DW(DW), .RESET_PC(RESET_PC)) u_seq (
      .clk(clk), .rst_n(rst_n), .halt(halt),
      .mem_addr(m_addr), .mem_we(m_we), .mem_wdata(m_wdata), .mem_rdata(m_rdata),
      .pc(pc), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .done(done)
   );

endmodule

// File: tb/tcpu_tb.sv
module tcpu_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt = 1'b0;
   logic       ext_we = 1'b0;
   logic [7:0] ext_addr = 8'h00, ext_wdata = 8'h00;
   logic [7:0] ext_rdata, pc, reg_a, reg_b, reg_c;
   logic       done;
   int         checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   tcpu u_dut (.*);

   // prog(12 bytes) steps pc a b c maddr mval
   localparam int VW = 148;
   localparam logic [VW-1:0] VEC [19] = '{
      {96'h41_05_51_FB_61_7F_00_00_00_00_00_00, 4'd3, 8'h26, 8'h05, 8'hFB, 8'h7F, 8'h20, 8'h41}, // R5 R2
      {96'h41_09_12_62_00_00_00_00_00_00_00_00, 4'd3, 8'h24, 8'h09, 8'h09, 8'h09, 8'h20, 8'h41}, // R4 mov
      {96'h71_10_AA_C2_10_00_00_00_00_00_00_00, 4'd2, 8'h25, 8'hAA, 8'h00, 8'h00, 8'h10, 8'hAA}, // R3 R2
      {96'h71_11_33_71_12_44_F2_13_11_00_00_00, 4'd3, 8'h29, 8'h00, 8'h00, 8'h00, 8'h13, 8'h33}, // R3 order
      {96'h41_20_13_00_00_00_00_00_00_00_00_00, 4'd2, 8'h23, 8'h20, 8'h41, 8'h00, 8'h20, 8'h41}, // R4 mfr
      {96'h41_05_51_14_14_00_00_00_00_00_00_00, 4'd3, 8'h25, 8'h05, 8'h14, 8'h00, 8'h14, 8'h05}, // R4 mtr
      {96'h11_30_00_00_00_00_00_00_00_00_00_00, 4'd1, 8'h30, 8'h00, 8'h00, 8'h00, 8'h20, 8'h11}, // R5 jmp
      {96'h41_07_51_07_45_2C_00_00_00_00_00_00, 4'd3, 8'h2C, 8'h07, 8'h07, 8'h00, 8'h20, 8'h41}, // R6 jeq taken
      {96'h41_07_51_08_45_2C_00_00_00_00_00_00, 4'd3, 8'h26, 8'h07, 8'h08, 8'h00, 8'h20, 8'h41}, // R6 jeq not
      {96'h41_07_51_08_46_2C_00_00_00_00_00_00, 4'd3, 8'h2C, 8'h07, 8'h08, 8'h00, 8'h20, 8'h41}, // R6 jne
      {96'h41_FF_51_01_47_2C_00_00_00_00_00_00, 4'd3, 8'h2C, 8'hFF, 8'h01, 8'h00, 8'h20, 8'h41}, // R6 jlt signed
      {96'h41_01_51_FF_47_2C_00_00_00_00_00_00, 4'd3, 8'h26, 8'h01, 8'hFF, 8'h00, 8'h20, 8'h41}, // R6 jlt not
      {96'hA1_40_00_00_00_00_00_00_00_00_00_00, 4'd1, 8'h40, 8'h00, 8'h00, 8'h22, 8'h20, 8'hA1}, // R7 cal reg
      {96'hB1_15_40_00_00_00_00_00_00_00_00_00, 4'd1, 8'h40, 8'h00, 8'h00, 8'h00, 8'h15, 8'h23}, // R7 cal mem
      {96'h41_2A_C1_00_00_00_00_00_00_00_00_00, 4'd2, 8'h2A, 8'h2A, 8'h00, 8'h00, 8'h20, 8'h41}, // R7 ret
      {96'h41_20_51_18_21_00_00_00_00_00_00_00, 4'd3, 8'h25, 8'h21, 8'h19, 8'h00, 8'h18, 8'h41}, // R8 scp
      {96'h08_41_03_00_00_00_00_00_00_00_00_00, 4'd2, 8'h23, 8'h03, 8'h00, 8'h00, 8'h20, 8'h08}, // R9 nop
      {96'h71_16_3C_F1_16_00_00_00_00_00_00_00, 4'd2, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h16, 8'h3C}, // R7 ret mem
      {96'h71_17_09_51_09_75_17_2C_00_00_00_00, 4'd3, 8'h2C, 8'h00, 8'h09, 8'h00, 8'h17, 8'h09}  // R6 R2 mem
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      ext_we = 1'b1; ext_addr = a; ext_wdata = d;
      @(negedge clk);
      ext_we = 1'b0;
   endtask

   task automatic run(input int n, output int seen);
      int cyc = 0;
      seen = 0;
      while (seen < n && cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (done) seen++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 pc", pc, 8'h20);
      check("R1 a", reg_a, 8'h00);
      check("R1 done", {7'd0, done}, 8'h00);

      foreach (VEC[i]) begin
         logic [VW-1:0] v = VEC[i];
         @(negedge clk); rst_n = 1'b0;
         for (int k = 0; k < 12; k++) load(8'h20 + 8'(k), v[147 - 8*k -: 8]);
         @(negedge clk); rst_n = 1'b1;
         run(int'(v[51:48]), seen);
         check($sformatf("R11 steps vec%0d", i), 8'(seen), 8'(v[51:48]));
         check($sformatf("vec%0d pc", i), pc, v[47:40]);
         check($sformatf("vec%0d a", i), reg_a, v[39:32]);
         check($sformatf("vec%0d b", i), reg_b, v[31:24]);
         check($sformatf("vec%0d c", i), reg_c, v[23:16]);
         ext_addr = v[15:8];
         #0.1;
         check($sformatf("vec%0d mem", i), ext_rdata, v[7:0]);
         @(negedge clk);
         check("R11 done low after pulse", {7'd0, done}, 8'h00);
      end

      // R1 again after a run: registers cleared, pc back to start
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 b cleared", reg_b, 8'h00);
      check("R1 pc reset", pc, 8'h20);

      // R10 halt from release: nothing moves, no done
      load(8'h20, 8'h41); load(8'h21, 8'h05); load(8'h22, 8'h51); load(8'h23, 8'h06);
      load(8'h50, 8'h11);
      check("R12 loader readback", ext_rdata, 8'h11);
      halt = 1'b1;
      @(negedge clk); rst_n = 1'b1;
      seen = 0;
      for (int k = 0; k < 10; k++) begin @(negedge clk); if (done) seen++; end
      check("R10 pc frozen", pc, 8'h20);
      check("R10 a frozen", reg_a, 8'h00);
      check("R10 no done", 8'(seen), 8'h00);
      halt = 1'b0;
      run(2, seen);
      check("R10 resume a", reg_a, 8'h05);
      check("R10 resume b", reg_b, 8'h06);

      // R12 loader write while running is ignored
      @(negedge clk);
      ext_we = 1'b1; ext_addr = 8'h50; ext_wdata = 8'h99;
      @(negedge clk); ext_we = 1'b0;
      #0.1;
      check("R12 write ignored in run", ext_rdata, 8'h11);

      // R13 pc wrap 0xFF -> 0x00
      @(negedge clk); rst_n = 1'b0;
      load(8'h20, 8'h11); load(8'h21, 8'hFF);
      load(8'hFF, 8'h41); load(8'h00, 8'h09);
      @(negedge clk); rst_n = 1'b1;
      run(2, seen);
      check("R13 wrap a", reg_a, 8'h09);
      check("R13 wrap pc", pc, 8'h01);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule